// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load Interlock

This unit lives in the decode stage of a five-stage, in-order integer pipeline. On every cycle it compares the two source register numbers of the instruction in decode with the destination registers of the instructions now in execute and memory. It then registers one bypass select per ALU operand. Those registered selects steer the operand multiplexers in the following cycle, when the decoded instruction has moved into execute. Because the choice is made a cycle early, the execute stage sees a select that comes straight from a flop, with no compare logic in front of it.

Only read-after-write conflicts need handling. Registers are read in decode and written in write-back, so the other two orderings cannot occur. A value still being loaded in execute cannot reach an instruction directly behind it. In that case the unit raises a combinational stall, which holds fetch and decode, and a bubble flag, which makes the decode/execute register load a no-op. A producer already in write-back needs no bypass, because the register file passes a write through to a read in the same cycle.

The block moves no data stream. All its pins are plain control signals with no valid/ready handshake, and it never pushes back on anything other than through the stall output.

Top module: `fwd_interlock_unit`

## Requirements
- R1: After reset, and until the first decode evaluation, both selects read 2'b00 (register file). With `id_valid` low, `stall_if_id` and `bubble_id_ex` are low.
- R2: If a source matches the register written by a non-load instruction in execute, that operand's select is 2'b10 (execute/memory register) in the cycle after the compare.
- R3: If a source matches the register written by the instruction in memory, and execute does not also match, that operand's select is 2'b01 (memory/write-back register) in the next cycle.
- R4: When both execute and memory write the same source register, the younger producer wins, so the select is 2'b10.
- R5: A source with no matching producer in execute or memory gets 2'b00 in the next cycle. This covers a producer that is already in write-back.
- R6: Source register 0 never causes a bypass or a stall, even when a stage reports writing register 0.
- R7: A stage whose write-enable is low is ignored, whatever its destination and load flag hold.
- R8: While `id_valid` is high, a load in execute whose destination matches either nonzero source drives `stall_if_id` and `bubble_id_ex` high in the same cycle. The selects registered at that edge are 2'b00, for the bubble.
- R9: A load in memory that matches a source causes no stall and gives 2'b01 in the next cycle.
- R10: Operand A (`id_rs1`) and operand B (`id_rs2`) are resolved independently and may receive different selects in the same cycle.
- R11: While `id_valid` is low, no stall is raised and the next-cycle selects are 2'b00.
- R12: Selects are not held across a stall. In the cycle after a stall they are recomputed from the shifted stage contents, so a load that has moved into memory gives 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | 5 | Operand A source register |
| id_rs2 | input | 5 | Operand B source register |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_rd | input | 5 | Destination of instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mem_rd | input | 5 | Destination of instruction in memory |
| fwd_a_sel | output | 2 | Registered operand A select: 00 reg file, 01 mem/wb, 10 ex/mem |
| fwd_b_sel | output | 2 | Registered operand B select, same encoding |
| stall_if_id | output | 1 | Hold fetch and decode this cycle |
| bubble_id_ex | output | 1 | Load a no-op into decode/execute this cycle |

## Verification
The assertions assume that the stage inputs are settled before each rising edge. They also assume that the pipeline around the unit behaves as the interlock expects: after a stall, the bubble appears in execute with its write-enable low, and the load moves on into memory. The directed part of the stimulus models that shift explicitly for the stall-recompute case. The random part draws register numbers from a small range so that matches, register 0 and load flags occur often. Its inputs are otherwise unconstrained, because the unit is purely a function of the current stage contents.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic hit_ex;
    logic hit_mem;
    logic load_ex;
  } src_hit_t;
endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          ex_wen,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_is_load,
  input  logic          mem_wen,
  input  logic [AW-1:0] mem_rd,
  output src_hit_t      hit
);
  logic src_live;

  always_comb begin
    src_live    = |src;
    hit.hit_ex  = src_live && ex_wen && (ex_rd == src);
    hit.hit_mem = src_live && mem_wen && (mem_rd == src);
    hit.load_ex = hit.hit_ex && ex_is_load;
  end
endmodule

// File: rtl/fwd_sel_pick.sv
module fwd_sel_pick
  import fwd_pkg::*;
(
  input  src_hit_t hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (hit.hit_ex)       sel = FWD_EXMEM;
    else if (hit.hit_mem) sel = FWD_MEMWB;
    else                  sel = FWD_RF;
  end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          ex_wen,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_is_load,
  input  logic          mem_wen,
  input  logic [AW-1:0] mem_rd,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          stall_if_id,
  output logic          bubble_id_ex
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][AW-1:0] srcs;
  src_hit_t                hits  [NOPS];
  fwd_sel_e                picks [NOPS];
  fwd_sel_e                sel_q [NOPS];
  logic [NOPS-1:0]         load_hit;
  logic                    stall;

  assign srcs = {id_rs2, id_rs1};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_src_match #(.AW(AW)) u_match (
      .src       (srcs[g]),
      .ex_wen    (ex_wen),
      .ex_rd     (ex_rd),
      .ex_is_load(ex_is_load),
      .mem_wen   (mem_wen),
      .mem_rd    (mem_rd),
      .hit       (hits[g])
    );

    fwd_sel_pick u_pick (
      .hit(hits[g]),
      .sel(picks[g])
    );

    assign load_hit[g] = hits[g].load_ex;

    // Selects are recomputed every cycle; a stall or empty decode slot sends a bubble.
    always_ff @(posedge clk) begin
      if (!rst_n)                 sel_q[g] <= FWD_RF;
      else if (!id_valid || stall) sel_q[g] <= FWD_RF;
      else                        sel_q[g] <= picks[g];
    end
  end

  assign stall        = id_valid && (|load_hit);
  assign stall_if_id  = stall;
  assign bubble_id_ex = stall;
  assign fwd_a_sel    = sel_q[0];
  assign fwd_b_sel    = sel_q[1];

  // Encoding 2'b11 is never produced.
  assert_sel_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

  // A stall needs a real instruction in decode.
  assert_stall_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall_if_id |-> id_valid);

  // The instruction entering execute after a stall is a bubble.
  assert_bubble_sel_rf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_if_id |=> (fwd_a_sel == 2'b00) && (fwd_b_sel == 2'b00));

  // Register 0 is never bypassed.
  assert_x0_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |=> (fwd_a_sel == 2'b00));

  // A memory-stage load alone never stalls.
  assert_mem_load_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wen) |-> !stall_if_id);
endmodule

// File: tb/fwd_interlock_unit_tb.sv
module fwd_interlock_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic id_valid = 0;
  logic [AW-1:0] id_rs1 = 0, id_rs2 = 0, ex_rd = 0, mem_rd = 0;
  logic ex_wen = 0, ex_is_load = 0, mem_wen = 0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic stall_if_id, bubble_id_ex;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_a = 0, exp_b = 0;
  string pend_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_interlock_unit #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_wen(ex_wen), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
    .mem_wen(mem_wen), .mem_rd(mem_rd),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .stall_if_id(stall_if_id), .bubble_id_ex(bubble_id_ex)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Behavioural model: 2 = younger (execute) producer, 1 = memory producer, 0 = register file.
  function automatic int model_sel(int src);
    if (src == 0) return 0;
    if (ex_wen && int'(ex_rd) == src) return 2;
    if (mem_wen && int'(mem_rd) == src) return 1;
    return 0;
  endfunction

  function automatic bit model_stall();
    if (!id_valid || !ex_wen || !ex_is_load || ex_rd == 0) return 0;
    return (ex_rd == id_rs1) || (ex_rd == id_rs2);
  endfunction

  task automatic step(input bit v, input int r1, input int r2,
                      input bit ew, input int erd, input bit eld,
                      input bit mw, input int mrd, input string tag);
    bit s;
    @(negedge clk);
    chk(int'(fwd_a_sel) == exp_a, {pend_tag, " sel A"}, fwd_a_sel, exp_a);
    chk(int'(fwd_b_sel) == exp_b, {pend_tag, " sel B"}, fwd_b_sel, exp_b);
    id_valid = v; id_rs1 = AW'(r1); id_rs2 = AW'(r2);
    ex_wen = ew; ex_rd = AW'(erd); ex_is_load = eld;
    mem_wen = mw; mem_rd = AW'(mrd);
    #1;
    s = model_stall();
    chk(stall_if_id == s, {tag, " stall"}, stall_if_id, s);
    chk(bubble_id_ex == s, {tag, " bubble"}, bubble_id_ex, s);
    if (!v || s) begin exp_a = 0; exp_b = 0; end
    else begin exp_a = model_sel(r1); exp_b = model_sel(r2); end
    pend_tag = tag;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00, "R1 reset sel", fwd_a_sel, 0);
    chk(stall_if_id == 0, "R1 reset stall", stall_if_id, 0);
    @(negedge clk); rst_n = 1;
    step(1, 3, 4, 1, 3, 0, 0, 0, "R2");
    step(1, 7, 9, 0, 0, 0, 1, 9, "R3");
    step(1, 6, 6, 1, 6, 0, 1, 6, "R4");
    step(1, 8, 2, 1, 5, 0, 1, 11, "R5");
    step(1, 0, 0, 1, 0, 1, 1, 0, "R6");
    step(1, 0, 12, 1, 0, 0, 1, 0, "R6");
    step(1, 13, 14, 0, 13, 1, 0, 14, "R7");
    step(1, 15, 1, 1, 15, 1, 0, 0, "R8");
    step(1, 2, 16, 1, 16, 1, 1, 2, "R8");
    step(1, 17, 3, 0, 0, 0, 1, 17, "R9");
    step(1, 18, 19, 1, 19, 0, 1, 18, "R10");
    step(0, 20, 21, 1, 20, 1, 1, 21, "R11");
    // Load-use then the pipeline shifts: bubble in execute, load in memory.
    step(1, 22, 5, 1, 22, 1, 1, 9, "R12");
    step(1, 22, 5, 0, 0, 0, 1, 22, "R12");
    step(1, 1, 1, 0, 0, 0, 0, 0, "R12");
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 4), $urandom_range(0, 4),
           $urandom_range(0, 1), $urandom_range(0, 4), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 4), "R10 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    chk(int'(fwd_a_sel) == exp_a, {pend_tag, " final A"}, fwd_a_sel, exp_a);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule